// File: doc/BRIEF.md
# Backplane Priority Arbiter

This block is the central arbiter on a shared backplane. Devices raise one of four interrupt request lines, for levels 4 to 7, or a single non-processor (DMA) request line. The arbiter answers with a single grant line. A device takes the bus by asserting the selection acknowledge line. It then drives the bus-busy line while it moves data.

DMA requests always win. An interrupt request is granted only when its level is strictly above the current processor priority, and only while the processor is not loading a new status word. Once a grant is out, the arbiter waits for an acknowledge. If none comes, and every request has gone away, a cycle timeout takes the grant back. A flag tells the processor-side data mover that a device holds the bus, so the processor can hold off its own transfers until the flag clears.

Top module: `bus_arb_master`

## Requirements
- R1: After synchronous reset, `grant` is all-zero and `dev_owns_bus` is low.
- R2: `grant` is never more than one-hot. Bit 0 to bit 3 stand for levels 4 to 7, and bit 4 stands for the DMA line.
- R3: On any clock edge that sees `sack` high, `grant` becomes zero and `dev_owns_bus` goes high. This holds whether or not requests are still present.
- R4: With `sack` low, no grant out and `req[4]` high, the next edge issues `grant = 5'b10000`. This ignores interrupt requests, `cpu_level` and `cpu_fetching`.
- R5: With only interrupt lines active, the level offered is the highest active line. Line i is level i+4, and the grant sets bit i of that line only.
- R6: An interrupt level is granted only if it is strictly greater than `cpu_level`. Lower active lines are never considered in its place.
- R7: While `cpu_fetching` is high, no interrupt grant is issued. DMA grants are still issued.
- R8: While a grant is out and unacknowledged, it stays unchanged, even if higher-priority requests arrive.
- R9: When a grant is out, `sack` is low and every request line is low, the grant is withdrawn on the edge after the counter has run for SACK_TIMEOUT cycles. The grant is therefore visible for SACK_TIMEOUT+1 cycles in total. `dev_owns_bus` clears on that same edge.
- R10: `dev_owns_bus` clears on an edge that sees both `sack` and `bbsy` low. It stays high while `bbsy` is high and `sack` is low.
- R11: The timeout never withdraws a grant while any request line is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 5 | Request lines: bits 0..3 are levels 4..7, bit 4 is DMA |
| sack | input | 1 | Selection acknowledge from the device taking the bus |
| bbsy | input | 1 | Bus busy, driven by the current data master |
| cpu_level | input | 3 | Current processor priority level |
| cpu_fetching | input | 1 | High while the processor loads a new status word |
| grant | output | 5 | Grant lines, at most one high, same bit order as `req` |
| dev_owns_bus | output | 1 | A device has taken or still holds the bus |

## Verification
Several properties are checked on every cycle: the grant is one-hot or zero, an acknowledge drops the grant and raises the ownership flag, an outstanding grant never changes to another line, the DMA line always wins from idle, a fetch blocks interrupt grants, and idle bus lines clear the ownership flag. The timeout length, and the rule that the timeout waits while requests remain, can only be shown by the bench. The same holds for the exact level chosen from mixed request patterns and the strict comparison against the processor level. The bench covers these with a vector table and directed sequences.

// File: rtl/arb_pkg.sv
// Shared constants for the backplane arbiter: request-line layout and the
// level numbering of interrupt lines.
package arb_pkg;
    localparam int BR_LINES = 4;               // interrupt request lines
    localparam int REQ_W    = BR_LINES + 1;    // plus one DMA line
    localparam int NPR_IDX  = BR_LINES;        // DMA line sits above the BR lines
    localparam int LVL_W    = 3;               // priority level width
    localparam logic [LVL_W-1:0] BR_BASE_LVL = 3'd4; // level of line 0
endpackage

// File: rtl/arb_level_pick.sv
// Interrupt level picker.
// Finds the highest active interrupt line and reports its level (line i is
// level BR_BASE_LVL+i) and a one-hot mask of that line.
// Assumes: purely combinational; the caller qualifies 'any'.
module arb_level_pick
    import arb_pkg::*;
(
    input  logic [BR_LINES-1:0] br,
    output logic                any,
    output logic [LVL_W-1:0]    level,
    output logic [BR_LINES-1:0] onehot
);
    // Scan upward so the highest active line wins.
    always_comb begin
        any    = |br;
        level  = BR_BASE_LVL;
        onehot = '0;
        for (int i = 0; i < BR_LINES; i++) begin
            if (br[i]) begin
                level     = BR_BASE_LVL + LVL_W'(i);
                onehot    = '0;
                onehot[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/arb_sack_timer.sv
// Acknowledge timeout counter.
// Loaded with LIMIT when a grant is issued, counts down to zero, and is
// forced to zero when an acknowledge is seen. 'expired' is high at zero.
// Assumes: load and clear are never high together (clear wins).
module arb_sack_timer #(
    parameter int LIMIT = 16,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic clear,
    output logic expired
);
    logic [CW-1:0] cnt_q;

    // Down-counter with load and clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (clear)      cnt_q <= '0;
        else if (load)       cnt_q <= CW'(LIMIT);
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // A fresh load must keep the timer running for the next cycle.
    p_load_runs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> !expired);
endmodule

// File: rtl/bus_arb_master.sv
// Backplane priority arbiter.
// Issues at most one grant at a time: DMA first, otherwise the highest
// interrupt level above the processor priority (and never during a status
// word fetch). An acknowledge removes the grant and marks the bus as held by
// a device; an unanswered grant is withdrawn after SACK_TIMEOUT cycles once
// all requests have gone. Assumes all inputs are synchronous to clk.
module bus_arb_master
    import arb_pkg::*;
#(
    parameter int SACK_TIMEOUT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REQ_W-1:0] req,
    input  logic             sack,
    input  logic             bbsy,
    input  logic [LVL_W-1:0] cpu_level,
    input  logic             cpu_fetching,
    output logic [REQ_W-1:0] grant,
    output logic             dev_owns_bus
);
    localparam logic [REQ_W-1:0] NPR_GRANT = REQ_W'(1) << NPR_IDX;

    logic [REQ_W-1:0]    grant_q;
    logic                owns_q;
    logic                br_any;
    logic [LVL_W-1:0]    br_level;
    logic [BR_LINES-1:0] br_onehot;
    logic                idle, br_ok, issue_npr, issue_br, withdraw, expired;

    arb_level_pick u_pick (
        .br     (req[BR_LINES-1:0]),
        .any    (br_any),
        .level  (br_level),
        .onehot (br_onehot)
    );

    arb_sack_timer #(.LIMIT(SACK_TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (issue_npr | issue_br),
        .clear   (sack),
        .expired (expired)
    );

    // Decide this cycle's grant action.
    always_comb begin
        idle      = (grant_q == '0);
        br_ok     = br_any && (br_level > cpu_level) && !cpu_fetching;
        issue_npr = !sack && idle && req[NPR_IDX];
        issue_br  = !sack && idle && !req[NPR_IDX] && br_ok;
        withdraw  = !sack && !idle && (req == '0) && expired;
    end

    // Grant register: acknowledge clears, idle issues, timeout withdraws.
    always_ff @(posedge clk) begin
        if (!rst_n)         grant_q <= '0;
        else if (sack)      grant_q <= '0;
        else if (issue_npr) grant_q <= NPR_GRANT;
        else if (issue_br)  grant_q <= {1'b0, br_onehot};
        else if (withdraw)  grant_q <= '0;
    end

    // Device-owns-bus flag: set by acknowledge, cleared by idle bus or timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)                owns_q <= 1'b0;
        else if (sack)             owns_q <= 1'b1;
        else if (!bbsy || withdraw) owns_q <= 1'b0;
    end

    assign grant        = grant_q;
    assign dev_owns_bus = owns_q;

    p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_sack_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sack |=> (grant == '0) && dev_owns_bus);

    p_npr_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sack && grant == '0 && req[NPR_IDX]) |=> (grant == NPR_GRANT));

    p_strict_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sack && grant == '0 && !req[NPR_IDX] && br_level <= cpu_level)
        |=> (grant == '0));

    p_fetch_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sack && grant == '0 && !req[NPR_IDX] && cpu_fetching) |=> (grant == '0));

    p_grant_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && !sack) |=> (grant == '0 || grant == $past(grant)));

    p_owns_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sack && !bbsy) |=> !dev_owns_bus);

    p_no_timeout_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && !sack && req != '0) |=> (grant == $past(grant)));
endmodule

// File: tb/tb_bus_arb_master.sv
// Bench for bus_arb_master: vector table from idle, then directed sequences.
module tb_bus_arb_master;
    localparam int TO = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] req = '0;
    logic       sack = 1'b0;
    logic       bbsy = 1'b0;
    logic [2:0] cpu_level = '0;
    logic       cpu_fetching = 1'b0;
    logic [4:0] grant;
    logic       dev_owns_bus;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    bus_arb_master #(.SACK_TIMEOUT(TO)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .sack(sack), .bbsy(bbsy),
        .cpu_level(cpu_level), .cpu_fetching(cpu_fetching),
        .grant(grant), .dev_owns_bus(dev_owns_bus)
    );

    always #5 clk = ~clk;

    // {req, cpu_level, cpu_fetching, expected grant}
    localparam logic [13:0] VEC [12] = '{
        {5'b00001, 3'd0, 1'b0, 5'b00001},
        {5'b01000, 3'd6, 1'b0, 5'b01000},
        {5'b01000, 3'd7, 1'b0, 5'b00000},
        {5'b00100, 3'd6, 1'b0, 5'b00000},
        {5'b00100, 3'd5, 1'b0, 5'b00100},
        {5'b00111, 3'd0, 1'b0, 5'b00100},
        {5'b01010, 3'd3, 1'b0, 5'b01000},
        {5'b10000, 3'd7, 1'b1, 5'b10000},
        {5'b11111, 3'd0, 1'b0, 5'b10000},
        {5'b01111, 3'd0, 1'b1, 5'b00000},
        {5'b00011, 3'd4, 1'b0, 5'b00010},
        {5'b00011, 3'd5, 1'b0, 5'b00000}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Return to idle: acknowledge once, then free the bus.
    task automatic settle();
        req = '0; sack = 1'b1; bbsy = 1'b0; tick();
        sack = 1'b0; tick();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk); tick(); tick();
        check("R1 grant after reset", grant, 0);
        check("R1 owns after reset", dev_owns_bus, 0);
        rst_n = 1'b1; tick();

        // Vector table: R4 R5 R6 R7, each from idle.
        for (int v = 0; v < 12; v++) begin
            req = VEC[v][13:9]; cpu_level = VEC[v][8:6]; cpu_fetching = VEC[v][5];
            tick();
            check($sformatf("R4 R5 R6 R7 vector %0d", v), grant, VEC[v][4:0]);
            settle();
        end
        cpu_fetching = 1'b0; cpu_level = 3'd0;

        // R11 and R8: grant held while requests remain and higher ones arrive.
        req = 5'b00001; tick();
        check("R5 BR4 granted", grant, 5'b00001);
        for (int k = 0; k < TO + 5; k++) tick();
        check("R11 no timeout with request held", grant, 5'b00001);
        req = 5'b11001; tick(); tick(); tick();
        check("R8 grant unchanged by higher requests", grant, 5'b00001);

        // R3 and R10: acknowledge with requests still present.
        sack = 1'b1; bbsy = 1'b1; tick();
        check("R3 grant dropped on sack", grant, 0);
        check("R3 owns set on sack", dev_owns_bus, 1);
        req = '0; sack = 1'b0; tick();
        check("R10 owns kept while bbsy", dev_owns_bus, 1);
        check("R2 no grant while idle after sack", grant, 0);
        bbsy = 1'b0; tick();
        check("R10 owns cleared when bus idle", dev_owns_bus, 0);

        // R9: timeout with bbsy high so only the timeout can clear ownership.
        sack = 1'b1; bbsy = 1'b1; tick();
        sack = 1'b0; tick();
        check("R10 owns set before timeout test", dev_owns_bus, 1);
        req = 5'b00100; cpu_level = 3'd2; tick();
        check("R9 BR6 granted", grant, 5'b00100);
        req = '0;
        begin
            int held = 0;
            bit owns_before = 1'b0;
            for (int k = 1; k <= TO + 3; k++) begin
                owns_before = dev_owns_bus;
                tick();
                held = k;
                if (grant == '0) break;
            end
            check("R9 grant withdrawn after timeout edges", held, TO + 1);
            check("R9 owns held until timeout", owns_before, 1);
            check("R9 owns cleared by timeout", dev_owns_bus, 0);
        end
        bbsy = 1'b0; tick();

        // R7: fetch blocks BR but NPR still wins.
        cpu_fetching = 1'b1; req = 5'b01000; cpu_level = 3'd0; tick();
        check("R7 fetch blocks BR7", grant, 0);
        req = 5'b11000; tick();
        check("R7 DMA granted during fetch", grant, 5'b10000);
        settle();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule